// File: doc/BRIEF.md
# External Asynchronous Memory Read Sequencer

This block turns read requests from an internal port into read cycles on external asynchronous memory. On the memory side it drives one active-low select per bank, a shared active-low read strobe and the address. Each access runs through four phases. First, select and address are set up for one clock. Next, the strobe is held low for the programmed wait-state count, and a device that is not yet ready can stretch this phase with an acknowledge input. Then the word is captured as the strobe rises. Finally, select and address are held for a programmed number of clocks.

The block keeps a minimum strobe-high spacing between one read and the next access. That spacing depends on three things: whether the next access is a read or a write, whether it targets the bank just read or a different one, and a predisable mode bit. The idle count and fixed floors are combined with max() rules. The request port grants each access only after the spacing it needs has elapsed. Write requests take part in that spacing, but this block makes no write cycle for them.

The configuration inputs are expected to stay stable while an access is in flight.

Top module: `amem_rd_seq`

## Requirements
- R1: After reset, every select and the read strobe are high, `rsp_valid` is low and `req_ready` is high, because no spacing is owed.
- R2: A read to bank b drives bit b of `mem_sel_n` low, and no other bit. Select and address are valid for exactly one clock with the strobe high before the strobe falls, and they stay unchanged while the strobe is low. `req_ready` is low while the strobe is low.
- R3: With `mem_ack` high, the strobe stays low for max(`cfg_wait`, 1) clocks.
- R4: The strobe rises only after a clock in which `mem_ack` is high and the wait count has run out. Any low clock of `mem_ack` prolongs the low phase.
- R5: `rsp_data` takes the value of `mem_rdata` sampled at the clock edge where the strobe rises. `rsp_valid` is high for exactly the one clock in which the strobe is first high again.
- R6: Select and address stay asserted for `cfg_rhold` clocks after the strobe rises, then the select is released if no new access follows.
- R7: The gap is the number of strobe-high clocks between two reads. With `cfg_predis` = 0, the gap is `cfg_rhold`+1 for a read to the same bank, and `cfg_rhold`+`cfg_idle`+1 for a read to a different bank.
- R8: With `cfg_predis` = 1, the gap is `cfg_rhold`+3+1 for a read to the same bank, and `cfg_rhold`+max(`cfg_idle`,3)+1 for a read to a different bank.
- R9: A write that follows a read, to any bank and in either mode, is granted so that its acceptance clock plus two lies `cfg_rhold`+max(`cfg_idle`,4)+1 clocks after the first strobe-high clock.
- R10: No gap is shorter than two clocks, because one accept clock and one setup clock always come before a strobe.
- R11: Accepting a write (`req_write` = 1) produces no select, strobe or `rsp_valid` activity. The access after a write owes no gap, so `req_ready` is high in the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wait | input | WS_W | Wait-state count (0 acts as 1) |
| cfg_rhold | input | RH_W | Read-hold clocks |
| cfg_idle | input | IC_W | Idle clocks for bank or type change |
| cfg_predis | input | 1 | Predisable mode bit |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request granted this clock |
| req_write | input | 1 | 1 = write request, 0 = read |
| req_bank | input | $clog2(NUM_BANKS) | Target bank index |
| req_addr | input | ADDR_W | Target address |
| rsp_valid | output | 1 | One-clock pulse with read data |
| rsp_data | output | DATA_W | Captured read word |
| mem_sel_n | output | NUM_BANKS | Active-low bank selects |
| mem_rd_n | output | 1 | Active-low read strobe |
| mem_addr | output | ADDR_W | Memory address |
| mem_rdata | input | DATA_W | Memory read data |
| mem_ack | input | 1 | Device ready; low stretches the strobe |

## Verification
A wrong phase counter shows at once as a strobe whose low length or hold length is off by one or more clocks. The bench measures that length edge to edge on each access. A stale record of the previous bank or access type does not show until the following access. There it appears as a grant that comes too early or too late, so each spacing rule is tested with a pair of accesses issued back to back. A capture taken on the wrong edge returns a filler word in place of the addressed data within the same access, because the memory model drives valid data only while acknowledge is high and the strobe is low.

// File: rtl/amem_pkg.sv
package amem_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2,
    ST_HOLD   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/amem_rst_sync.sv
module amem_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_in_n,
  output logic rst_out_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_out_n = sync_q[STAGES-1];
endmodule

// File: rtl/amem_gap_tracker.sv
module amem_gap_tracker #(
  parameter int NUM_BANKS = 4,
  parameter int RH_W      = 3,
  parameter int IC_W      = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [RH_W-1:0]              cfg_rhold,
  input  logic [IC_W-1:0]              cfg_idle,
  input  logic                         cfg_predis,
  input  logic [$clog2(NUM_BANKS)-1:0] req_bank,
  input  logic                         req_write,
  input  logic                         strobe_end,
  input  logic [$clog2(NUM_BANKS)-1:0] done_bank,
  input  logic                         write_acc,
  output logic                         gap_ok
);
  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int RH_MAX = (1 << RH_W) - 1;
  localparam int IC_MAX = (1 << IC_W) - 1;
  localparam int GAP_W  = $clog2(RH_MAX + IC_MAX + 6);
  localparam logic [GAP_W-1:0] HI_SAT = '1;
  localparam logic [GAP_W-1:0] FLOOR_RD_SAME = GAP_W'(3);
  localparam logic [GAP_W-1:0] FLOOR_RD_DIFF = GAP_W'(3);
  localparam logic [GAP_W-1:0] FLOOR_WR      = GAP_W'(4);

  logic              prev_rd_q, prev_rd_d, prev_en;
  logic [BANK_W-1:0] prev_bank_q, prev_bank_d;
  logic [GAP_W-1:0]  hi_q, hi_d;
  logic              hi_en;
  logic [GAP_W-1:0]  idle_x, extra, need;
  logic              same_bank;

  assign idle_x    = GAP_W'(cfg_idle);
  assign same_bank = (req_bank == prev_bank_q);

  always_comb begin
    if (req_write)
      extra = (idle_x > FLOOR_WR) ? idle_x : FLOOR_WR;
    else if (same_bank)
      extra = cfg_predis ? FLOOR_RD_SAME : '0;
    else if (cfg_predis)
      extra = (idle_x > FLOOR_RD_DIFF) ? idle_x : FLOOR_RD_DIFF;
    else
      extra = idle_x;
    need = GAP_W'(cfg_rhold) + extra + GAP_W'(1);
  end

  // hi_q counts strobe-high clocks since the last rise (1 in the first one)
  assign gap_ok = !prev_rd_q || (hi_q >= need - GAP_W'(1));

  always_comb begin
    prev_en     = strobe_end || write_acc;
    prev_rd_d   = strobe_end;
    prev_bank_d = strobe_end ? done_bank : prev_bank_q;
    hi_en       = strobe_end || (hi_q != HI_SAT);
    hi_d        = strobe_end ? GAP_W'(1) : hi_q + GAP_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_rd_q   <= 1'b0;
      prev_bank_q <= '0;
    end else if (prev_en) begin
      prev_rd_q   <= prev_rd_d;
      prev_bank_q <= prev_bank_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_q <= HI_SAT;
    else if (hi_en) hi_q <= hi_d;
  end
endmodule

// File: rtl/amem_strobe_fsm.sv
module amem_strobe_fsm
  import amem_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int WS_W      = 5,
  parameter int RH_W      = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [WS_W-1:0]              cfg_wait,
  input  logic [RH_W-1:0]              cfg_rhold,
  input  logic                         acc_rd,
  input  logic [ADDR_W-1:0]            req_addr,
  input  logic [$clog2(NUM_BANKS)-1:0] req_bank,
  input  logic                         mem_ack,
  input  logic [DATA_W-1:0]            mem_rdata,
  output logic                         can_accept,
  output logic                         strobe_end,
  output logic [$clog2(NUM_BANKS)-1:0] cur_bank,
  output logic [NUM_BANKS-1:0]         mem_sel_n,
  output logic                         mem_rd_n,
  output logic [ADDR_W-1:0]            mem_addr,
  output logic                         rsp_valid,
  output logic [DATA_W-1:0]            rsp_data
);
  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int CNT_W  = (WS_W > RH_W) ? WS_W : RH_W;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  seq_state_e           st_q, st_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [BANK_W-1:0]    bank_q, bank_d;
  logic [ADDR_W-1:0]    addr_q, addr_d;
  logic [NUM_BANKS-1:0] sel_n_q, sel_n_d, req_sel_n;
  logic                 rd_n_q, rd_n_d;
  logic                 vld_q, vld_d;
  logic [DATA_W-1:0]    dat_q;
  logic                 dat_en;
  logic [CNT_W-1:0]     wait_eff;
  logic                 last_beat;

  assign wait_eff  = (cfg_wait == '0) ? ONE : CNT_W'(cfg_wait);
  assign last_beat = (cnt_q <= ONE);

  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++)
      req_sel_n[b] = (req_bank != BANK_W'(b));
  end

  assign can_accept = (st_q == ST_IDLE) || (st_q == ST_HOLD);
  assign strobe_end = (st_q == ST_STROBE) && last_beat && mem_ack;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    bank_d  = bank_q;
    addr_d  = addr_q;
    sel_n_d = sel_n_q;
    rd_n_d  = rd_n_q;
    vld_d   = 1'b0;
    dat_en  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (acc_rd) begin
          st_d    = ST_SETUP;
          bank_d  = req_bank;
          addr_d  = req_addr;
          sel_n_d = req_sel_n;
        end
      end
      ST_SETUP: begin
        st_d   = ST_STROBE;
        rd_n_d = 1'b0;
        cnt_d  = wait_eff;
      end
      ST_STROBE: begin
        if (strobe_end) begin
          rd_n_d = 1'b1;
          vld_d  = 1'b1;
          dat_en = 1'b1;
          if (cfg_rhold == '0) begin
            sel_n_d = '1;
            st_d    = ST_IDLE;
          end else begin
            st_d  = ST_HOLD;
            cnt_d = CNT_W'(cfg_rhold);
          end
        end else if (!last_beat) begin
          cnt_d = cnt_q - ONE;
        end
      end
      ST_HOLD: begin
        if (acc_rd) begin
          st_d    = ST_SETUP;
          bank_d  = req_bank;
          addr_d  = req_addr;
          sel_n_d = req_sel_n;
        end else if (last_beat) begin
          sel_n_d = '1;
          st_d    = ST_IDLE;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      bank_q  <= '0;
      addr_q  <= '0;
      sel_n_q <= '1;
      rd_n_q  <= 1'b1;
      vld_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      bank_q  <= bank_d;
      addr_q  <= addr_d;
      sel_n_q <= sel_n_d;
      rd_n_q  <= rd_n_d;
      vld_q   <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dat_q <= '0;
    else if (dat_en) dat_q <= mem_rdata;
  end

  assign cur_bank  = bank_q;
  assign mem_sel_n = sel_n_q;
  assign mem_rd_n  = rd_n_q;
  assign mem_addr  = addr_q;
  assign rsp_valid = vld_q;
  assign rsp_data  = dat_q;
endmodule

// File: rtl/amem_rd_seq.sv
module amem_rd_seq #(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int WS_W      = 5,
  parameter int RH_W      = 3,
  parameter int IC_W      = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [WS_W-1:0]              cfg_wait,
  input  logic [RH_W-1:0]              cfg_rhold,
  input  logic [IC_W-1:0]              cfg_idle,
  input  logic                         cfg_predis,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic                         req_write,
  input  logic [$clog2(NUM_BANKS)-1:0] req_bank,
  input  logic [ADDR_W-1:0]            req_addr,
  output logic                         rsp_valid,
  output logic [DATA_W-1:0]            rsp_data,
  output logic [NUM_BANKS-1:0]         mem_sel_n,
  output logic                         mem_rd_n,
  output logic [ADDR_W-1:0]            mem_addr,
  input  logic [DATA_W-1:0]            mem_rdata,
  input  logic                         mem_ack
);
  localparam int BANK_W = $clog2(NUM_BANKS);

  logic              rst_sync_n;
  logic              can_accept, gap_ok, strobe_end;
  logic              acc, acc_rd, write_acc;
  logic [BANK_W-1:0] cur_bank;

  amem_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_in_n  (rst_n),
    .rst_out_n (rst_sync_n)
  );

  assign req_ready = can_accept && gap_ok;
  assign acc       = req_valid && req_ready;
  assign acc_rd    = acc && !req_write;
  assign write_acc = acc && req_write;

  amem_gap_tracker #(
    .NUM_BANKS (NUM_BANKS),
    .RH_W      (RH_W),
    .IC_W      (IC_W)
  ) u_gap (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cfg_rhold  (cfg_rhold),
    .cfg_idle   (cfg_idle),
    .cfg_predis (cfg_predis),
    .req_bank   (req_bank),
    .req_write  (req_write),
    .strobe_end (strobe_end),
    .done_bank  (cur_bank),
    .write_acc  (write_acc),
    .gap_ok     (gap_ok)
  );

  amem_strobe_fsm #(
    .NUM_BANKS (NUM_BANKS),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .WS_W      (WS_W),
    .RH_W      (RH_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cfg_wait   (cfg_wait),
    .cfg_rhold  (cfg_rhold),
    .acc_rd     (acc_rd),
    .req_addr   (req_addr),
    .req_bank   (req_bank),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .can_accept (can_accept),
    .strobe_end (strobe_end),
    .cur_bank   (cur_bank),
    .mem_sel_n  (mem_sel_n),
    .mem_rd_n   (mem_rd_n),
    .mem_addr   (mem_addr),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data)
  );
endmodule

// File: rtl/amem_rd_seq_chk.sv
module amem_rd_seq_chk #(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 16,
  parameter int WS_W      = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [WS_W-1:0]      cfg_wait,
  input logic                 req_ready,
  input logic                 rsp_valid,
  input logic [NUM_BANKS-1:0] mem_sel_n,
  input logic                 mem_rd_n,
  input logic [ADDR_W-1:0]    mem_addr,
  input logic                 mem_ack
);
  localparam int LC_W = WS_W + 2;
  logic [LC_W-1:0] low_cnt;
  logic [LC_W-1:0] weff;

  assign weff = (cfg_wait == '0) ? LC_W'(1) : LC_W'(cfg_wait);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          low_cnt <= '0;
    else if (mem_rd_n)                   low_cnt <= '0;
    else if (low_cnt != {LC_W{1'b1}})    low_cnt <= low_cnt + LC_W'(1);
  end

  // R2
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_sel_n));

  // R2
  setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_rd_n) |-> (mem_sel_n != '1) && $stable(mem_sel_n) && $stable(mem_addr));

  // R2
  strobe_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rd_n |-> $stable(mem_sel_n) && $stable(mem_addr) && !req_ready);

  // R3
  strobe_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_rd_n) |-> (low_cnt >= weff));

  // R4
  ack_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_rd_n && !mem_ack) |=> !mem_rd_n);

  // R5
  rsp_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_rd_n) |-> rsp_valid);

  // R5
  rsp_only_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $rose(mem_rd_n));
endmodule

bind amem_rd_seq amem_rd_seq_chk #(
  .NUM_BANKS (NUM_BANKS),
  .ADDR_W    (ADDR_W),
  .WS_W      (WS_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_wait  (cfg_wait),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_sel_n (mem_sel_n),
  .mem_rd_n  (mem_rd_n),
  .mem_addr  (mem_addr),
  .mem_ack   (mem_ack)
);

// File: tb/amem_rd_seq_tb.sv
module amem_rd_seq_tb;
  localparam int NB = 4, AW = 16, DW = 16;
  localparam logic [DW-1:0] KEY = 16'h3C5A;
  localparam logic [DW-1:0] FILL = 16'hDEAD;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] cfg_wait = 5'd2;
  logic [2:0] cfg_rhold = 3'd0, cfg_idle = 3'd0;
  logic cfg_predis = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_bank = '0;
  logic [AW-1:0] req_addr = '0;
  logic req_ready, rsp_valid, mem_rd_n;
  logic [DW-1:0] rsp_data, mem_rdata;
  logic [NB-1:0] mem_sel_n;
  logic [AW-1:0] mem_addr;
  logic mem_ack = 1'b1;

  int n_chk = 0, n_err = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  assign mem_rdata = (!mem_rd_n && mem_ack) ? (mem_addr ^ KEY) : FILL;

  amem_rd_seq #(.NUM_BANKS(NB), .ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wait(cfg_wait), .cfg_rhold(cfg_rhold),
    .cfg_idle(cfg_idle), .cfg_predis(cfg_predis), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_bank(req_bank),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_sel_n(mem_sel_n), .mem_rd_n(mem_rd_n), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack));

  // port monitor, sampled on falling edges
  int fall_cyc = 0, last_rise = 0, low_len = 0, last_gap = 0;
  int hold_len = 0, n_rsp = 0, n_fall = 0;
  bit have_rise = 0, hold_act = 0, rdy_at_fall = 0;
  logic prev_rd = 1'b1;
  logic [NB-1:0] prev_sel = '1, setup_sel = '1;
  logic [AW-1:0] prev_addr = '0, setup_addr = '0;
  logic [DW-1:0] last_data = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_rd && !mem_rd_n) begin
        fall_cyc = cyc; n_fall++; hold_act = 0;
        if (have_rise) last_gap = cyc - last_rise;
        setup_sel = (prev_sel == mem_sel_n) ? prev_sel : 'x;
        setup_addr = prev_addr;
        rdy_at_fall = req_ready;
      end
      if (!prev_rd && mem_rd_n) begin
        low_len = cyc - fall_cyc; last_rise = cyc; have_rise = 1;
        hold_act = 1; hold_len = 0;
      end
      if (mem_rd_n && hold_act) begin
        if (mem_sel_n != '1) hold_len++;
        else hold_act = 0;
      end
      if (rsp_valid) begin n_rsp++; last_data = rsp_data; end
      prev_rd = mem_rd_n; prev_sel = mem_sel_n; prev_addr = mem_addr;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] bank, input logic [AW-1:0] addr,
                      input bit wr, output int first_cyc, output int acc_cyc);
    @(negedge clk);
    req_valid = 1'b1; req_bank = bank; req_addr = addr; req_write = wr;
    #1;
    first_cyc = cyc;
    while (!req_ready) begin @(negedge clk); #1; end
    acc_cyc = cyc;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(mem_sel_n == '1, "R1 sel", int'(mem_sel_n), 15);
    chk(mem_rd_n == 1'b1, "R1 strobe", int'(mem_rd_n), 1);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", int'(rsp_valid), 0);
    chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
  endtask

  task automatic t_single(input logic [1:0] bank, input logic [AW-1:0] addr,
                          input int w, input int rh);
    int f, a, r0, weff;
    cfg_wait = 5'(w); cfg_rhold = 3'(rh);
    weff = (w == 0) ? 1 : w;
    r0 = n_rsp;
    send(bank, addr, 1'b0, f, a);
    idle(w + rh + 12);
    chk(setup_sel === ~(4'(1) << bank), "R2 setup select", int'(setup_sel), int'(~(4'(1) << bank)));
    chk(setup_addr == addr, "R2 setup address", int'(setup_addr), int'(addr));
    chk(rdy_at_fall == 1'b0, "R2 ready low in strobe", int'(rdy_at_fall), 0);
    chk(low_len == weff, "R3 strobe length", low_len, weff);
    chk(n_rsp == r0 + 1, "R5 rsp pulse count", n_rsp - r0, 1);
    chk(last_data == (addr ^ KEY), "R5 captured data", int'(last_data), int'(addr ^ KEY));
    chk(hold_len == rh, "R6 hold length", hold_len, rh);
  endtask

  task automatic t_ack(input int w, input int n);
    int f, a, exp;
    logic [AW-1:0] addr = 16'h0F1E;
    cfg_wait = 5'(w); cfg_rhold = 3'd1;
    send(2'd1, addr, 1'b0, f, a);
    while (mem_rd_n) @(negedge clk);
    mem_ack = 1'b0;
    repeat (n) @(negedge clk);
    mem_ack = 1'b1;
    idle(12);
    exp = (w > n + 1) ? w : n + 1;
    chk(low_len == exp, "R4 stretched strobe", low_len, exp);
    chk(last_data == (addr ^ KEY), "R4 data after ack", int'(last_data), int'(addr ^ KEY));
  endtask

  task automatic t_gap(input string req, input bit pd, input int rh, input int ic,
                       input logic [1:0] b1, input logic [1:0] b2, input bit wr2,
                       input int exp);
    int f, a, g;
    cfg_predis = pd; cfg_rhold = 3'(rh); cfg_idle = 3'(ic); cfg_wait = 5'd2;
    idle(35);
    send(b1, 16'h1200, 1'b0, f, a);
    send(b2, 16'h3400, wr2, f, a);
    if (wr2) g = a + 2 - last_rise;
    else begin
      idle(15);
      g = last_gap;
    end
    chk(g == exp, req, g, exp);
    idle(20);
  endtask

  task automatic t_write();
    int f, a, fw, aw, r0, nf0;
    bit quiet = 1;
    cfg_predis = 1'b0; cfg_rhold = 3'd1; cfg_idle = 3'd2; cfg_wait = 5'd2;
    idle(35);
    r0 = n_rsp; nf0 = n_fall;
    send(2'd2, 16'h5500, 1'b1, fw, aw);
    repeat (8) begin
      @(negedge clk);
      if (!mem_rd_n || mem_sel_n != '1 || rsp_valid) quiet = 0;
    end
    chk(quiet && n_rsp == r0 && n_fall == nf0, "R11 write is silent", int'(quiet), 1);
    send(2'd0, 16'h6600, 1'b1, fw, aw);
    send(2'd3, 16'h7700, 1'b0, f, a);
    chk(a == f, "R11 no gap after write", a - f, 0);
    idle(20);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_single(2'd0, 16'hA001, 3, 2);
    t_single(2'd3, 16'h0BC4, 0, 0);
    t_single(2'd2, 16'h7E57, 7, 5);
    t_ack(2, 4);
    t_ack(6, 1);
    t_gap("R7 same bank",        0, 2, 5, 2'd1, 2'd1, 0, 3);
    t_gap("R7 other bank",       0, 2, 5, 2'd1, 2'd2, 0, 8);
    t_gap("R8 same bank",        1, 1, 1, 2'd0, 2'd0, 0, 5);
    t_gap("R8 other bank floor", 1, 1, 1, 2'd0, 2'd3, 0, 5);
    t_gap("R8 other bank idle",  1, 1, 6, 2'd0, 2'd3, 0, 8);
    t_gap("R9 write floor",      0, 1, 2, 2'd1, 2'd1, 1, 6);
    t_gap("R9 write idle",       1, 2, 6, 2'd1, 2'd2, 1, 9);
    t_gap("R10 same floor",      0, 0, 0, 2'd2, 2'd2, 0, 2);
    t_gap("R10 other floor",     0, 0, 0, 2'd2, 2'd0, 0, 2);
    t_write();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", 100000, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule